// File: doc/BRIEF.md
# Bulk Receive Stream Deframer

This block sits behind the receive side of a bulk transfer engine. It takes the bytes of one bulk transfer as a byte-wide valid/ready stream, with a marker on the final byte, and cuts the stream into Ethernet frames. Every frame in the transfer is preceded by a four-byte little-endian header. The header holds an 11-bit byte count and a complemented copy of that count. Frames of odd length are followed by one alignment byte, so every header starts at an even offset within the transfer.

The block checks each header against its complemented copy. It rejects counts above a run-time maximum and counts that run past the end of the transfer. It discards alignment bytes and checks that the transfer ends exactly where a frame (with any pad byte) ends. Payload bytes go out on a byte stream with first-byte and last-byte flags. Problems are reported on two single-cycle error pulses: one for a bad header and one for a bad length. After an error, the rest of the transfer is consumed and discarded. The next transfer is parsed from its first byte.

Top module: `bulk_rx_deframer`

## Requirements
- R1: After reset, with no input, no output beat is offered, both error pulses are low, and the input is ready to take a header byte.
- R2: A header is four accepted bytes, least significant first. The length is byte0 plus byte1 bits 2:0 times 256. The check field is byte2 plus byte3 bits 2:0 times 256. All other header bits are ignored.
- R3: A valid header of length N is followed by exactly N output beats, carrying the next N input bytes in order. The first beat has out_sof set and the Nth beat has out_eof set.
- R4: If the check field is not the bitwise complement of the length, hdr_err pulses for one cycle, in the cycle after the fourth header byte is accepted. No payload is emitted, and every byte up to and including the transfer-end byte is dropped.
- R5: After a frame of odd length, exactly one byte is consumed and not emitted before the next header. A frame of even length is followed directly by the next header.
- R6: A length greater than max_len raises len_err and drops the rest of the transfer, with no beat emitted. A length equal to max_len is accepted.
- R7: If the transfer-end byte arrives inside a payload before the length is used up, that byte is emitted with out_eof set, and len_err pulses in the following cycle.
- R8: A transfer must end on its last payload byte (even length) or on its pad byte (odd length). If the transfer ends on any header byte, or on the last byte of an odd-length frame with no pad byte, len_err is raised.
- R9: A header of length zero with a good check produces no output beat. The next four bytes are taken as the next header.
- R10: While a payload byte is offered and out_ready is low, in_ready is low. No byte is lost or repeated across stalls.
- R11: Each error flag is a single-cycle pulse, and hdr_err and len_err are never high together. After a transfer-end byte, parsing restarts with a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_len | input | 11 | Largest accepted frame length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the bulk transfer |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream can take a payload byte |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame, or byte cut short by the transfer end |
| hdr_err | output | 1 | One-cycle pulse on a header check mismatch |
| len_err | output | 1 | One-cycle pulse on an oversize, truncated or misaligned transfer |

## Verification
The bench sends transfers that mix odd and even frame lengths, so that a design skipping the pad byte wrongly would shift every later header and report false header errors. It sends a zero-length header in mid-transfer and another as the final four bytes; a design that opens a payload for the first would hang or emit a stray beat, and one that lets the second through would miss the misalignment. It places the transfer-end marker inside a payload, on a header byte, and on an unpadded odd final byte, each of which must raise len_err. It also corrupts one check bit in a header followed by further well-formed frames; a design that resynchronises too early would leak those frames. Length is tested at max_len and one above it. The same traffic is repeated with downstream stalls, to catch lost or duplicated bytes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int BYTE_W     = 8;
    localparam int HDR_BYTES  = 4;
    localparam int LEN_W      = 11;
    localparam int CHK_LSB    = 16;
    localparam int HDR_W      = BYTE_W * HDR_BYTES;
    localparam int IDX_W      = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_DROP
    } rxd_state_e;

    typedef enum logic [1:0] {
        HV_OK,
        HV_EMPTY,
        HV_BADCHK,
        HV_TOOLONG
    } hdr_verdict_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        hdr_verdict_e     verdict;
    } hdr_info_t;

    function automatic logic [LEN_W-1:0] hdr_len(input logic [HDR_W-1:0] w);
        return w[LEN_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] hdr_chk(input logic [HDR_W-1:0] w);
        return w[CHK_LSB +: LEN_W];
    endfunction

endpackage

// File: rtl/rxd_hdr_capture.sv
module rxd_hdr_capture
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              last,
    input  logic [BYTE_W-1:0] din,
    output logic [HDR_W-1:0]  word,
    output logic              full
);

    logic [IDX_W-1:0]                      idx_q;
    logic [HDR_BYTES-2:0][BYTE_W-1:0]      held_q;

    assign full = (idx_q == IDX_W'(HDR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (take) begin
            if (last || full) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    for (genvar g = 0; g < HDR_BYTES - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q[g] <= '0;
            end else if (take && (idx_q == IDX_W'(g))) begin
                held_q[g] <= din;
            end
        end
        assign word[g*BYTE_W +: BYTE_W] = held_q[g];
    end

    // the final header byte is used straight from the input
    assign word[(HDR_BYTES-1)*BYTE_W +: BYTE_W] = din;

    // R8: a transfer end inside the header restarts collection at byte 0
    p_idx_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (take && last) |=> (idx_q == '0));

endmodule

// File: rtl/rxd_hdr_check.sv
module rxd_hdr_check
    import rxd_pkg::*;
(
    input  logic [HDR_W-1:0] word,
    input  logic [LEN_W-1:0] max_len,
    output hdr_info_t        info
);

    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] chk;
    logic             unused_hdr_bits;

    assign len = hdr_len(word);
    assign chk = hdr_chk(word);
    assign unused_hdr_bits = ^{word[CHK_LSB-1:LEN_W], word[HDR_W-1:CHK_LSB+LEN_W]};

    always_comb begin
        info.len = len;
        if (chk != ~len) begin
            info.verdict = HV_BADCHK;
        end else if (len > max_len) begin
            info.verdict = HV_TOOLONG;
        end else if (len == '0) begin
            info.verdict = HV_EMPTY;
        end else begin
            info.verdict = HV_OK;
        end
    end

endmodule

// File: rtl/rxd_frame_ctrl.sv
module rxd_frame_ctrl
    import rxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       out_ready,
    input  logic       hdr_full,
    input  hdr_info_t  hdr_info,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic       hdr_take,
    output logic       hdr_err,
    output logic       len_err
);

    rxd_state_e        st_q;
    logic [LEN_W-1:0]  rem_q;
    logic              odd_q;
    logic              first_q;
    logic              fire;
    logic              rem_one;

    assign in_ready  = (st_q == ST_PAY) ? out_ready : 1'b1;
    assign fire      = in_valid && in_ready;
    assign hdr_take  = fire && (st_q == ST_HDR);
    assign rem_one   = (rem_q == LEN_W'(1));
    assign out_valid = (st_q == ST_PAY) && in_valid;
    assign out_sof   = (st_q == ST_PAY) && first_q;
    assign out_eof   = (st_q == ST_PAY) && (rem_one || in_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HDR;
            rem_q   <= '0;
            odd_q   <= 1'b0;
            first_q <= 1'b0;
            hdr_err <= 1'b0;
            len_err <= 1'b0;
        end else begin
            hdr_err <= 1'b0;
            len_err <= 1'b0;
            if (fire) begin
                case (st_q)
                    ST_HDR: begin
                        if (in_last) begin
                            len_err <= 1'b1;
                        end else if (hdr_full) begin
                            case (hdr_info.verdict)
                                HV_BADCHK: begin
                                    hdr_err <= 1'b1;
                                    st_q    <= ST_DROP;
                                end
                                HV_TOOLONG: begin
                                    len_err <= 1'b1;
                                    st_q    <= ST_DROP;
                                end
                                HV_EMPTY: begin
                                    st_q <= ST_HDR;
                                end
                                default: begin
                                    st_q    <= ST_PAY;
                                    rem_q   <= hdr_info.len;
                                    odd_q   <= hdr_info.len[0];
                                    first_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_PAY: begin
                        first_q <= 1'b0;
                        rem_q   <= rem_q - LEN_W'(1);
                        if (in_last) begin
                            st_q <= ST_HDR;
                            if (!rem_one || odd_q) begin
                                len_err <= 1'b1;
                            end
                        end else if (rem_one) begin
                            st_q <= odd_q ? ST_PAD : ST_HDR;
                        end
                    end
                    ST_PAD: begin
                        st_q <= ST_HDR;
                    end
                    default: begin
                        if (in_last) begin
                            st_q <= ST_HDR;
                        end
                    end
                endcase
            end
        end
    end

    // R9: a payload phase is only open with bytes still owed
    p_pay_rem_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAY) |-> (rem_q != '0));

    // R5: the pad phase only follows a frame of odd length
    p_pad_after_odd_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAD) |-> odd_q);

    // R11: the two error pulses never coincide
    p_err_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(hdr_err && len_err));

    // R4: a header error is never accompanied by a payload beat
    p_hdr_err_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> !out_valid);

    // R10: a stalled payload byte leaves the remaining count untouched
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAY && in_valid && !out_ready) |=> $stable(rem_q));

endmodule

// File: rtl/bulk_rx_deframer.sv
module bulk_rx_deframer
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              hdr_err,
    output logic              len_err
);

    logic             hdr_take;
    logic             hdr_full;
    logic [HDR_W-1:0] hdr_word;
    hdr_info_t        hdr_info;

    rxd_hdr_capture u_capture (
        .clk  (clk),
        .rst  (rst),
        .take (hdr_take),
        .last (in_last),
        .din  (in_data),
        .word (hdr_word),
        .full (hdr_full)
    );

    rxd_hdr_check u_check (
        .word    (hdr_word),
        .max_len (max_len),
        .info    (hdr_info)
    );

    rxd_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_ready (out_ready),
        .hdr_full  (hdr_full),
        .hdr_info  (hdr_info),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .hdr_take  (hdr_take),
        .hdr_err   (hdr_err),
        .len_err   (len_err)
    );

    assign out_data = in_data;

    // R1: nothing is offered downstream without an input byte behind it
    p_out_needs_in_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_valid);

endmodule

// File: tb/tb_bulk_rx_deframer.sv
module tb_bulk_rx_deframer;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_N      = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] max_len = 11'd1518;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sof;
    logic        out_eof;
    logic        hdr_err;
    logic        len_err;

    bulk_rx_deframer dut (
        .clk(clk), .rst(rst), .max_len(max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .hdr_err(hdr_err), .len_err(len_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;

    logic [7:0] xfer [0:BUF_N-1];
    int         xn;
    logic [7:0] exp_d [0:BUF_N-1];
    bit         exp_s [0:BUF_N-1];
    bit         exp_e [0:BUF_N-1];
    int         en;
    logic [7:0] obs_d [0:BUF_N-1];
    bit         obs_s [0:BUF_N-1];
    bit         obs_e [0:BUF_N-1];
    int         on;
    int         herr_n;
    int         lerr_n;
    bit         stall = 1'b0;
    int         cyc = 0;

    // downstream ready pattern
    always begin
        @(negedge clk);
        #1;
        cyc++;
        out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    // monitor, sampled between the input drive time and the next rising edge
    always begin
        @(negedge clk);
        #3;
        if (!rst) begin
            if (out_valid && out_ready && on < BUF_N) begin
                obs_d[on] = out_data;
                obs_s[on] = out_sof;
                obs_e[on] = out_eof;
                on++;
            end
            if (hdr_err) herr_n++;
            if (len_err) lerr_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_xfer();
        xn = 0; en = 0; on = 0; herr_n = 0; lerr_n = 0;
    endtask

    task automatic add_raw(input logic [7:0] b);
        xfer[xn] = b;
        xn++;
    endtask

    task automatic add_exp(input logic [7:0] b, input bit s, input bit e);
        exp_d[en] = b; exp_s[en] = s; exp_e[en] = e;
        en++;
    endtask

    task automatic put_hdr(input int len, input bit bad);
        logic [10:0] l;
        logic [10:0] c;
        l = len[10:0];
        c = ~l;
        if (bad) c[0] = ~c[0];
        add_raw(l[7:0]);
        add_raw({5'b10100, l[10:8]});
        add_raw(c[7:0]);
        add_raw({5'b11111, c[10:8]});
    endtask

    // well-formed frame, payload expected at the output
    task automatic add_frame(input int len, input int seed, input bit pad);
        put_hdr(len, 1'b0);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'((seed + i * 7) & 8'hff);
            add_raw(b);
            add_exp(b, i == 0, i == len - 1);
        end
        if (pad && len[0]) add_raw(8'hEE);
    endtask

    task automatic push(input logic [7:0] b, input bit l);
        @(negedge clk);
        #1;
        in_valid = 1'b1; in_data = b; in_last = l;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #3;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send();
        for (int i = 0; i < xn; i++) push(xfer[i], i == xn - 1);
        repeat (4) @(posedge clk);
    endtask

    task automatic compare(input string req, input int exp_h, input int exp_l);
        check(on == en, {req, " beat count"}, on, en);
        for (int i = 0; i < en && i < on; i++) begin
            check(obs_d[i] == exp_d[i], {req, " data"}, obs_d[i], exp_d[i]);
            check(obs_s[i] == exp_s[i], {req, " sof"}, obs_s[i], exp_s[i]);
            check(obs_e[i] == exp_e[i], {req, " eof"}, obs_e[i], exp_e[i]);
        end
        check(herr_n == exp_h, {req, " hdr_err pulses"}, herr_n, exp_h);
        check(lerr_n == exp_l, {req, " len_err pulses"}, lerr_n, exp_l);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(hdr_err == 1'b0, "R1 hdr_err after reset", hdr_err, 0);
        check(len_err == 1'b0, "R1 len_err after reset", len_err, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    endtask

    // R2 R3 R5: mixed odd and even frames, pad on the final frame
    task automatic t_mixed();
        clear_xfer();
        add_frame(6, 3, 1'b1);
        add_frame(5, 40, 1'b1);
        add_frame(1, 90, 1'b1);
        add_frame(7, 17, 1'b1);
        send();
        compare("R3 R5 mixed lengths", 0, 0);
    endtask

    // R10: same traffic under downstream stalls
    task automatic t_stall();
        stall = 1'b1;
        clear_xfer();
        add_frame(9, 5, 1'b1);
        add_frame(12, 60, 1'b1);
        send();
        stall = 1'b0;
        compare("R10 backpressure", 0, 0);
    endtask

    // R4 then R11 recovery
    task automatic t_bad_check();
        clear_xfer();
        add_frame(3, 11, 1'b1);
        put_hdr(6, 1'b1);
        for (int i = 0; i < 6; i++) add_raw(8'h55);
        put_hdr(2, 1'b0);
        add_raw(8'h01); add_raw(8'h02);
        send();
        compare("R4 header check mismatch", 1, 0);
        clear_xfer();
        add_frame(2, 200, 1'b1);
        send();
        compare("R11 recovery after drop", 0, 0);
    endtask

    // R6: one above and exactly at the limit
    task automatic t_max_len();
        max_len = 11'd40;
        clear_xfer();
        put_hdr(41, 1'b0);
        for (int i = 0; i < 41; i++) add_raw(8'hA5);
        add_raw(8'hEE);
        send();
        compare("R6 length above max_len", 0, 1);
        clear_xfer();
        add_frame(40, 9, 1'b1);
        send();
        compare("R6 length equal to max_len", 0, 0);
        max_len = 11'd1518;
    endtask

    // R7: transfer ends inside a payload
    task automatic t_truncated();
        clear_xfer();
        put_hdr(10, 1'b0);
        for (int i = 0; i < 5; i++) begin
            add_raw(8'(8'h30 + i));
            add_exp(8'(8'h30 + i), i == 0, i == 4);
        end
        send();
        compare("R7 truncated payload", 0, 1);
    endtask

    // R8: misaligned transfer ends
    task automatic t_bad_end();
        clear_xfer();
        add_frame(4, 70, 1'b1);
        add_raw(8'h01); add_raw(8'h02); add_raw(8'h03);
        send();
        compare("R8 end inside header", 0, 1);
        clear_xfer();
        add_frame(2, 80, 1'b1);
        put_hdr(0, 1'b0);
        send();
        compare("R8 trailing empty header", 0, 1);
        clear_xfer();
        add_frame(3, 120, 1'b0);
        send();
        compare("R8 odd frame missing pad", 0, 1);
    endtask

    // R9: empty frame in mid transfer
    task automatic t_empty();
        clear_xfer();
        add_frame(2, 33, 1'b1);
        put_hdr(0, 1'b0);
        add_frame(3, 150, 1'b1);
        send();
        compare("R9 zero length frame", 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_mixed();
        t_stall();
        t_bad_check();
        t_max_len();
        t_truncated();
        t_bad_end();
        t_empty();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule